// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block holds the device-side protocol state of a single control endpoint. A packet layer in front of it has already decoded tokens, collects the bytes of each received data packet, and reports the host's reply to each packet the device sends. From these events the sequencer moves each control transfer through three stages. The setup stage captures the eight-byte request record. The optional data stage runs in either direction. The status stage runs in the direction opposite to the data stage.

For every token the sequencer decides the answer, one cycle after the triggering event. The answer is an acknowledge, a halt (stall), or a data payload of a given length that a payload source elsewhere fills. The sequencer keeps the running byte total, sizes each device-to-host payload against the configured maximum, and decides when the data stage is complete. A halted endpoint answers every data or status token with a stall until the next setup token, which also aborts any transfer in progress.

The stage code on the `stage` port and its transitions are as follows:
- IDLE=0 leads to SETUP on a setup token, from any stage.
- SETUP=1 leads to DATA_IN, DATA_OUT or STATUS_IN once the record is accepted, and back to IDLE if it is rejected.
- DATA_IN=2 leads to STATUS_OUT wait on completion, or to STATUS_OUT receive on an early OUT token.
- DATA_OUT=3 leads to DATA_OUT receive on an OUT token.
- DATA_OUT receive=4 leads to DATA_OUT or STATUS_IN.
- STATUS_OUT wait=5 leads to STATUS_OUT receive=6, which returns to IDLE.
- STATUS_IN=7 returns to IDLE.
- HALTED=8 is entered from 3, 4, 5, 6 and 7.

Top module: `ctrl_ep_sequencer`

## Requirements
- R1: While reset is asserted and after reset is released, the block is in IDLE. `resp_valid`, `xfer_done` and `halted` are 0, and `req_len` and `req_dir` are 0.
- R2: A setup packet of exactly 8 bytes is answered with ACK (`resp_code`=1) in the cycle after `rx_end`. It commits `req_dir` from bit 7 of byte 0 and `req_len` from byte 6 (low) and byte 7 (high). A setup packet of any other length gets no answer, leaves `req_dir`/`req_len` unchanged and returns to IDLE.
- R3: The maximum payload is 8 << `mps_code` (8, 16, 32 or 64 bytes) when `full_speed`=1, and 8 bytes when `full_speed`=0, whatever the value of `mps_code`.
- R4: In DATA_IN each IN token is answered with DATA (`resp_code`=3) and `resp_len` = min(maximum payload, requested length minus bytes already sent). The byte total advances only when the host acknowledges (`hs_valid` with `hs_ack`=1). An unacknowledged payload is offered again at the same length.
- R5: A device-to-host data stage is complete, and the stage becomes STATUS_OUT wait, when an acknowledged payload brings the total to the requested length or is shorter than the maximum payload. Otherwise the stage stays DATA_IN.
- R6: In a host-to-device data stage, each OUT payload within the limits is answered with ACK. When the total reaches the requested length the stage becomes STATUS_IN; otherwise it returns to DATA_OUT.
- R7: An OUT data payload longer than the maximum payload, or one that would take the total past the requested length, is answered with STALL (`resp_code`=2) and the endpoint halts.
- R8: After the data stage is complete, a token in the data direction is answered with STALL and the endpoint halts. An IN token in STATUS_OUT wait, or an OUT token in STATUS_IN, is such a token. So is an IN token while DATA_OUT is still incomplete.
- R9: A request of length 0 goes from SETUP straight to STATUS_IN. In STATUS_IN an IN token is answered with a zero-length DATA. A host acknowledge then pulses `xfer_done` and returns to IDLE; without an acknowledge the stage stays in STATUS_IN.
- R10: In the status-out stage a zero-length OUT packet is answered with ACK and pulses `xfer_done`. A non-empty one is answered with STALL and the endpoint halts.
- R11: While halted, every IN or OUT token is answered with STALL and `halted` stays 1. A setup token clears the halt, aborts any transfer and restarts the setup stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_speed | input | 1 | 1 = full-speed payload sizing, 0 = fixed 8-byte payloads |
| mps_code | input | 2 | Maximum payload select, size = 8 << code at full speed |
| tok_valid | input | 1 | Token event strobe |
| tok_pid | input | 2 | Token kind: 0 setup, 1 IN, 2 OUT, 3 ignored |
| rx_valid | input | 1 | One received data byte is present |
| rx_data | input | 8 | Received data byte |
| rx_end | input | 1 | End of a good received data packet |
| hs_valid | input | 1 | Host reply to the last device payload has arrived |
| hs_ack | input | 1 | 1 = host acknowledged, 0 = no acknowledge |
| resp_valid | output | 1 | An answer is issued this cycle |
| resp_code | output | 2 | Answer kind: 1 ACK, 2 STALL, 3 DATA |
| resp_len | output | 7 | Payload length when the answer is DATA |
| halted | output | 1 | Endpoint is halted |
| stage | output | 4 | Current stage code |
| req_dir | output | 1 | Committed request direction, 1 = device to host |
| req_len | output | 16 | Committed requested length |
| xfer_done | output | 1 | One-cycle pulse when a status stage completes |

## Verification
Device-to-host transfers are driven with lengths that are an exact multiple of the maximum payload and with lengths that leave a remainder. This separates completion by exact count from completion by short payload, and shows which payload is trimmed. Payloads left unacknowledged and then retried show whether the byte total advances only on acknowledge. Host-to-device transfers send payloads that fit, payloads one byte over the maximum and payloads that overshoot the requested length, so that accept and halt decisions are told apart. Setup packets of 7, 8 and 9 bytes, zero-length requests, wrong-direction tokens after completion and a setup token in the middle of a transfer cover the edges of the stage machine. All four payload sizes and the low-speed override are tried.

// File: rtl/cep_pkg.sv
package cep_pkg;

    localparam int SETUP_BYTES = 8;
    localparam int MIN_PAYLOAD = 8;
    localparam int LEN_LO_IDX  = 6;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_SETUP    = 4'd1,
        ST_DIN      = 4'd2,
        ST_DOUT     = 4'd3,
        ST_DOUT_RX  = 4'd4,
        ST_STAT_OUT = 4'd5,
        ST_STAT_RX  = 4'd6,
        ST_STAT_IN  = 4'd7,
        ST_HALT     = 4'd8
    } stage_e;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2,
        TK_RSVD  = 2'd3
    } tok_e;

    typedef enum logic [1:0] {
        RS_NONE  = 2'd0,
        RS_ACK   = 2'd1,
        RS_STALL = 2'd2,
        RS_DATA  = 2'd3
    } resp_e;

endpackage

// File: rtl/cep_mps_sel.sv
module cep_mps_sel
    import cep_pkg::*;
#(
    parameter int PLEN_W = 7
) (
    input  logic              full_speed,
    input  logic [1:0]        mps_code,
    output logic [PLEN_W-1:0] mps
);

    localparam logic [PLEN_W-1:0] BASE = PLEN_W'(MIN_PAYLOAD);

    always_comb begin
        if (full_speed) begin
            mps = BASE << mps_code;
        end else begin
            mps = BASE;
        end
    end

endmodule

// File: rtl/cep_setup_capture.sv
module cep_setup_capture
    import cep_pkg::*;
#(
    parameter int REC_BYTES = SETUP_BYTES,
    parameter int LEN_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [7:0]       din,
    input  logic             commit,
    output logic             stg_ok,
    output logic             stg_dir,
    output logic [LEN_W-1:0] stg_len,
    output logic             req_dir,
    output logic [LEN_W-1:0] req_len
);

    localparam int IDX_W    = $clog2(REC_BYTES + 2);
    localparam int LEN_BYTES = LEN_W / 8;
    localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(REC_BYTES);
    localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(REC_BYTES + 1);

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            idx <= '0;
        end else if (wr && idx != IDX_OVER) begin
            idx <= idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_dir <= 1'b0;
        end else if (wr && idx == '0) begin
            stg_dir <= din[7];
        end
    end

    for (genvar g = 0; g < LEN_BYTES; g++) begin : g_len_byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_len[g*8 +: 8] <= '0;
            end else if (wr && idx == IDX_W'(LEN_LO_IDX + g)) begin
                stg_len[g*8 +: 8] <= din;
            end
        end
    end

    assign stg_ok = (idx == IDX_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_dir <= 1'b0;
            req_len <= '0;
        end else if (commit) begin
            req_dir <= stg_dir;
            req_len <= stg_len;
        end
    end

endmodule

// File: rtl/cep_byte_ledger.sv
module cep_byte_ledger #(
    parameter int TOT_W = 16,
    parameter int PKT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             pkt_clr,
    input  logic             pkt_inc,
    input  logic             add_en,
    input  logic [TOT_W-1:0] add_val,
    output logic [TOT_W-1:0] total,
    output logic [PKT_W-1:0] pkt
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + add_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all || pkt_clr) begin
            pkt <= '0;
        end else if (pkt_inc && pkt != '1) begin
            pkt <= pkt + 1'b1;
        end
    end

endmodule

// File: rtl/ctrl_ep_sequencer.sv
module ctrl_ep_sequencer
    import cep_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int PLEN_W = 7,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_speed,
    input  logic [1:0]        mps_code,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_end,
    input  logic              hs_valid,
    input  logic              hs_ack,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    output logic [PLEN_W-1:0] resp_len,
    output logic              halted,
    output logic [3:0]        stage,
    output logic              req_dir,
    output logic [LEN_W-1:0]  req_len,
    output logic              xfer_done
);

    localparam int SUM_W = LEN_W + 1;

    stage_e st, st_nx;
    resp_e  rsp_nx;
    logic [PLEN_W-1:0] rlen_nx;
    logic              done_nx;

    logic [PLEN_W-1:0] mps;
    logic              cap_clr, cap_wr, cap_commit;
    logic              stg_ok, stg_dir;
    logic [LEN_W-1:0]  stg_len;
    logic              led_clr, pkt_clr, pkt_inc, add_en;
    logic [LEN_W-1:0]  add_val;
    logic [LEN_W-1:0]  total;
    logic [CNT_W-1:0]  pkt_cnt;
    logic              pend, pend_set, pend_clr;
    logic [PLEN_W-1:0] pend_len_q, pend_len_nx;

    logic [LEN_W-1:0]  remaining;
    logic [PLEN_W-1:0] in_len_nx;
    logic [SUM_W-1:0]  sum_pkt, sum_in, req_x;
    logic              tok_setup, tok_in, tok_out;

    cep_mps_sel #(.PLEN_W(PLEN_W)) u_mps (
        .full_speed (full_speed),
        .mps_code   (mps_code),
        .mps        (mps)
    );

    cep_setup_capture #(.REC_BYTES(SETUP_BYTES), .LEN_W(LEN_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cap_clr),
        .wr      (cap_wr),
        .din     (rx_data),
        .commit  (cap_commit),
        .stg_ok  (stg_ok),
        .stg_dir (stg_dir),
        .stg_len (stg_len),
        .req_dir (req_dir),
        .req_len (req_len)
    );

    cep_byte_ledger #(.TOT_W(LEN_W), .PKT_W(CNT_W)) u_led (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (led_clr),
        .pkt_clr (pkt_clr),
        .pkt_inc (pkt_inc),
        .add_en  (add_en),
        .add_val (add_val),
        .total   (total),
        .pkt     (pkt_cnt)
    );

    assign tok_setup = tok_valid && (tok_pid == TK_SETUP);
    assign tok_in    = tok_valid && (tok_pid == TK_IN);
    assign tok_out   = tok_valid && (tok_pid == TK_OUT);

    assign remaining = req_len - total;
    assign in_len_nx = (remaining > LEN_W'(mps)) ? mps : remaining[PLEN_W-1:0];
    assign req_x     = {1'b0, req_len};
    assign sum_pkt   = {1'b0, total} + SUM_W'(pkt_cnt);
    assign sum_in    = {1'b0, total} + SUM_W'(pend_len_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions and answer selection
    always_comb begin
        st_nx       = st;
        rsp_nx      = RS_NONE;
        rlen_nx     = '0;
        done_nx     = 1'b0;
        cap_clr     = 1'b0;
        cap_wr      = 1'b0;
        cap_commit  = 1'b0;
        led_clr     = 1'b0;
        pkt_clr     = 1'b0;
        pkt_inc     = 1'b0;
        add_en      = 1'b0;
        add_val     = '0;
        pend_set    = 1'b0;
        pend_clr    = 1'b0;
        pend_len_nx = '0;
        if (tok_setup) begin
            st_nx    = ST_SETUP;
            cap_clr  = 1'b1;
            led_clr  = 1'b1;
            pend_clr = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                end
                ST_SETUP: begin
                    if (rx_valid) begin
                        cap_wr = 1'b1;
                    end else if (rx_end) begin
                        if (stg_ok) begin
                            rsp_nx     = RS_ACK;
                            cap_commit = 1'b1;
                            if (stg_len == '0) begin
                                st_nx = ST_STAT_IN;
                            end else if (stg_dir) begin
                                st_nx = ST_DIN;
                            end else begin
                                st_nx = ST_DOUT;
                            end
                        end else begin
                            st_nx = ST_IDLE;
                        end
                    end
                end
                ST_DIN: begin
                    if (tok_in) begin
                        rsp_nx      = RS_DATA;
                        rlen_nx     = in_len_nx;
                        pend_set    = 1'b1;
                        pend_len_nx = in_len_nx;
                    end else if (tok_out) begin
                        st_nx   = ST_STAT_RX;
                        pkt_clr = 1'b1;
                    end else if (hs_valid && pend) begin
                        pend_clr = 1'b1;
                        if (hs_ack) begin
                            add_en  = 1'b1;
                            add_val = LEN_W'(pend_len_q);
                            if (sum_in == req_x || pend_len_q < mps) begin
                                st_nx = ST_STAT_OUT;
                            end
                        end
                    end
                end
                ST_DOUT: begin
                    if (tok_out) begin
                        st_nx   = ST_DOUT_RX;
                        pkt_clr = 1'b1;
                    end else if (tok_in) begin
                        rsp_nx = RS_STALL;
                        st_nx  = ST_HALT;
                    end
                end
                ST_DOUT_RX: begin
                    if (rx_valid) begin
                        pkt_inc = 1'b1;
                    end else if (rx_end) begin
                        if (pkt_cnt > CNT_W'(mps) || sum_pkt > req_x) begin
                            rsp_nx = RS_STALL;
                            st_nx  = ST_HALT;
                        end else begin
                            rsp_nx  = RS_ACK;
                            add_en  = 1'b1;
                            add_val = LEN_W'(pkt_cnt);
                            st_nx   = (sum_pkt == req_x) ? ST_STAT_IN : ST_DOUT;
                        end
                    end
                end
                ST_STAT_OUT: begin
                    if (tok_out) begin
                        st_nx   = ST_STAT_RX;
                        pkt_clr = 1'b1;
                    end else if (tok_in) begin
                        rsp_nx = RS_STALL;
                        st_nx  = ST_HALT;
                    end
                end
                ST_STAT_RX: begin
                    if (rx_valid) begin
                        pkt_inc = 1'b1;
                    end else if (rx_end) begin
                        if (pkt_cnt == '0) begin
                            rsp_nx  = RS_ACK;
                            done_nx = 1'b1;
                            st_nx   = ST_IDLE;
                        end else begin
                            rsp_nx = RS_STALL;
                            st_nx  = ST_HALT;
                        end
                    end
                end
                ST_STAT_IN: begin
                    if (tok_in) begin
                        rsp_nx      = RS_DATA;
                        pend_set    = 1'b1;
                        pend_len_nx = '0;
                    end else if (tok_out) begin
                        rsp_nx = RS_STALL;
                        st_nx  = ST_HALT;
                    end else if (hs_valid && pend) begin
                        pend_clr = 1'b1;
                        if (hs_ack) begin
                            done_nx = 1'b1;
                            st_nx   = ST_IDLE;
                        end
                    end
                end
                ST_HALT: begin
                    if (tok_in || tok_out) begin
                        rsp_nx = RS_STALL;
                    end
                end
                default: begin
                    st_nx = ST_IDLE;
                end
            endcase
        end
    end

    // outstanding device payload
    always_ff @(posedge clk) begin
        if (!rst_n || pend_clr) begin
            pend       <= 1'b0;
            pend_len_q <= '0;
        end else if (pend_set) begin
            pend       <= 1'b1;
            pend_len_q <= pend_len_nx;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RS_NONE;
            resp_len   <= '0;
            xfer_done  <= 1'b0;
        end else begin
            resp_valid <= (rsp_nx != RS_NONE);
            resp_code  <= rsp_nx;
            resp_len   <= rlen_nx;
            xfer_done  <= done_nx;
        end
    end

    assign halted = (st == ST_HALT);
    assign stage  = st;

endmodule

// File: rtl/cep_chk.sv
module cep_chk #(
    parameter int PLEN_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full_speed,
    input logic [1:0]        mps_code,
    input logic              tok_valid,
    input logic [1:0]        tok_pid,
    input logic              rx_end,
    input logic              resp_valid,
    input logic [1:0]        resp_code,
    input logic [PLEN_W-1:0] resp_len,
    input logic              halted,
    input logic [3:0]        stage,
    input logic              xfer_done
);

    // R7
    stall_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd2) |-> halted);

    // R11
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !(tok_valid && tok_pid == 2'd0)) |=> halted);

    // R11
    setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_pid == 2'd0) |=> (!halted && stage == 4'd1));

    // R2
    ack_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd1) |-> $past(rx_end));

    // R4
    data_after_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd3) |-> $past(tok_valid && tok_pid == 2'd1));

    // R3
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd3) |->
            (resp_len <= ($past(full_speed) ? (PLEN_W'(8) << $past(mps_code)) : PLEN_W'(8))));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (stage == 4'd0 && !halted && resp_valid == $past(rx_end)));

endmodule

bind ctrl_ep_sequencer cep_chk u_chk (.*);

// File: tb/tb_ctrl_ep_sequencer.sv
`timescale 1ns/1ps
module tb_ctrl_ep_sequencer;

    localparam int ACK = 1, STALL = 2, DATA = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       full_speed = 1'b1;
    logic [1:0] mps_code = 2'd3;
    logic       tok_valid = 1'b0;
    logic [1:0] tok_pid = 2'd0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'd0;
    logic       rx_end = 1'b0;
    logic       hs_valid = 1'b0;
    logic       hs_ack = 1'b0;
    logic       resp_valid;
    logic [1:0] resp_code;
    logic [6:0] resp_len;
    logic       halted;
    logic [3:0] stage;
    logic       req_dir;
    logic [15:0] req_len;
    logic       xfer_done;

    ctrl_ep_sequencer dut (
        .clk(clk), .rst_n(rst_n), .full_speed(full_speed), .mps_code(mps_code),
        .tok_valid(tok_valid), .tok_pid(tok_pid), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_end(rx_end), .hs_valid(hs_valid), .hs_ack(hs_ack),
        .resp_valid(resp_valid), .resp_code(resp_code), .resp_len(resp_len),
        .halted(halted), .stage(stage), .req_dir(req_dir), .req_len(req_len),
        .xfer_done(xfer_done)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string mtag = "R1";

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // behavioural reference model
    int m_st = 0, m_cnt = 0, m_pkt = 0, m_rlen = 0, m_rdir = 0, m_pend = 0, m_plen = 0, m_mps = 8;
    int e_rv = 0, e_code = 0, e_len = 0, e_done = 0;
    logic [7:0] q[$];

    task automatic m_stall();
        e_rv = 1; e_code = STALL; m_st = 8;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pkt = 0; m_rlen = 0; m_rdir = 0; m_pend = 0; m_plen = 0;
            e_rv = 0; e_code = 0; e_len = 0; e_done = 0;
            q.delete();
        end else begin
            m_mps = full_speed ? (8 << mps_code) : 8;
            e_rv = 0; e_code = 0; e_len = 0; e_done = 0;
            if (tok_valid && tok_pid == 2'd0) begin
                m_st = 1; q.delete(); m_cnt = 0; m_pend = 0; m_plen = 0; m_pkt = 0;
            end else begin
                case (m_st)
                    1: if (rx_valid) q.push_back(rx_data);
                       else if (rx_end) begin
                           if (q.size() == 8) begin
                               e_rv = 1; e_code = ACK;
                               m_rdir = int'(q[0][7]);
                               m_rlen = int'({q[7], q[6]});
                               m_st = (m_rlen == 0) ? 7 : (m_rdir == 1 ? 2 : 3);
                           end else m_st = 0;
                       end
                    2: if (tok_valid && tok_pid == 2'd1) begin
                           e_rv = 1; e_code = DATA;
                           e_len = (m_rlen - m_cnt > m_mps) ? m_mps : m_rlen - m_cnt;
                           m_pend = 1; m_plen = e_len;
                       end else if (tok_valid && tok_pid == 2'd2) begin
                           m_st = 6; m_pkt = 0;
                       end else if (hs_valid && m_pend == 1) begin
                           m_pend = 0;
                           if (hs_ack) begin
                               m_cnt += m_plen;
                               if (m_cnt == m_rlen || m_plen < m_mps) m_st = 5;
                           end
                           m_plen = 0;
                       end
                    3: if (tok_valid && tok_pid == 2'd2) begin m_st = 4; m_pkt = 0; end
                       else if (tok_valid && tok_pid == 2'd1) m_stall();
                    4: if (rx_valid) m_pkt++;
                       else if (rx_end) begin
                           if (m_pkt > m_mps || m_cnt + m_pkt > m_rlen) m_stall();
                           else begin
                               e_rv = 1; e_code = ACK; m_cnt += m_pkt;
                               m_st = (m_cnt == m_rlen) ? 7 : 3;
                           end
                       end
                    5: if (tok_valid && tok_pid == 2'd2) begin m_st = 6; m_pkt = 0; end
                       else if (tok_valid && tok_pid == 2'd1) m_stall();
                    6: if (rx_valid) m_pkt++;
                       else if (rx_end) begin
                           if (m_pkt == 0) begin e_rv = 1; e_code = ACK; e_done = 1; m_st = 0; end
                           else m_stall();
                       end
                    7: if (tok_valid && tok_pid == 2'd1) begin
                           e_rv = 1; e_code = DATA; e_len = 0; m_pend = 1; m_plen = 0;
                       end else if (tok_valid && tok_pid == 2'd2) m_stall();
                       else if (hs_valid && m_pend == 1) begin
                           m_pend = 0;
                           if (hs_ack) begin e_done = 1; m_st = 0; end
                       end
                    8: if (tok_valid && (tok_pid == 2'd1 || tok_pid == 2'd2)) begin
                           e_rv = 1; e_code = STALL;
                       end
                    default: ;
                endcase
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk({mtag, " resp_valid"}, int'(resp_valid), e_rv);
            chk({mtag, " resp_code"}, int'(resp_code), e_code);
            chk({mtag, " resp_len"}, int'(resp_len), e_len);
            chk({mtag, " xfer_done"}, int'(xfer_done), e_done);
            chk({mtag, " halted"}, int'(halted), m_st == 8 ? 1 : 0);
            chk({mtag, " stage"}, int'(stage), m_st);
            chk({mtag, " req_dir"}, int'(req_dir), m_rdir);
            chk({mtag, " req_len"}, int'(req_len), m_rlen);
        end
    end

    always @(negedge clk) begin
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual %0d cycles expected < 100000", cyc);
            finish_run();
        end
    end

    // stimulus tasks: start and end just after a falling edge
    task automatic token(input int pid);
        tok_valid = 1'b1; tok_pid = 2'(pid);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic payload(input int n, input logic [7:0] b[]);
        for (int i = 0; i < n; i++) begin
            rx_valid = 1'b1;
            rx_data = (i < b.size()) ? b[i] : 8'h5a;
            @(negedge clk);
        end
        rx_valid = 1'b0;
        rx_end = 1'b1;
        @(negedge clk);
        rx_end = 1'b0;
    endtask

    task automatic setup(input int dir, input int len, input int n);
        logic [7:0] b[];
        b = new[8];
        b[0] = dir ? 8'h80 : 8'h00; b[1] = 8'h06; b[2] = 8'h00; b[3] = 8'h01;
        b[4] = 8'h00; b[5] = 8'h00; b[6] = 8'(len); b[7] = 8'(len >> 8);
        token(0);
        payload(n, b);
    endtask

    task automatic out_pkt(input int n);
        logic [7:0] b[];
        b = new[0];
        token(2);
        payload(n, b);
    endtask

    task automatic hs(input logic ack);
        hs_valid = 1'b1; hs_ack = ack;
        @(negedge clk);
        hs_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        mtag = "R1";
        chk("R1 reset resp_valid", int'(resp_valid), 0);
        chk("R1 reset halted", int'(halted), 0);
        chk("R1 reset stage", int'(stage), 0);
        chk("R1 reset req_len", int'(req_len), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset xfer_done", int'(xfer_done), 0);

        // device-to-host with remainder, retry on missing ack
        mtag = "R4"; full_speed = 1'b1; mps_code = 2'd3;
        setup(1, 150, 8);
        chk("R2 setup ack", int'(resp_code), ACK);
        chk("R2 req_len", int'(req_len), 150);
        chk("R2 req_dir", int'(req_dir), 1);
        token(1); chk("R4 first payload", int'(resp_len), 64);
        hs(1'b0);
        token(1); chk("R4 retry payload", int'(resp_len), 64);
        hs(1'b1);
        token(1); chk("R4 second payload", int'(resp_len), 64);
        hs(1'b1);
        token(1); chk("R4 trimmed last", int'(resp_len), 22);
        hs(1'b1);
        chk("R5 short completes", int'(stage), 5);
        mtag = "R10";
        out_pkt(0);
        chk("R10 status ack", int'(resp_code), ACK);
        chk("R10 done pulse", int'(xfer_done), 1);

        // exact-multiple completion, then wrong-direction token
        mtag = "R5";
        setup(1, 128, 8);
        token(1); hs(1'b1);
        chk("R5 not yet complete", int'(stage), 2);
        token(1); hs(1'b1);
        chk("R5 exact completes", int'(stage), 5);
        mtag = "R8";
        token(1);
        chk("R8 IN after done stalls", int'(resp_code), STALL);
        chk("R8 halted", int'(halted), 1);
        mtag = "R11";
        token(2); chk("R11 OUT while halted", int'(resp_code), STALL);
        token(1); chk("R11 IN while halted", int'(resp_code), STALL);
        hs(1'b1); chk("R11 still halted", int'(halted), 1);
        setup(0, 4, 8);
        chk("R11 halt cleared", int'(halted), 0);
        chk("R11 new direction", int'(stage), 3);
        mtag = "R8";
        out_pkt(4); chk("R6 reaches status in", int'(stage), 7);
        token(2); chk("R8 OUT after done stalls", int'(resp_code), STALL);

        // payload size selection
        mtag = "R3";
        for (int c = 0; c < 3; c++) begin
            mps_code = 2'(c);
            setup(1, 100, 8);
            token(1);
            chk("R3 full-speed size", int'(resp_len), 8 << c);
        end
        full_speed = 1'b0; mps_code = 2'd3;
        setup(1, 20, 8);
        token(1); chk("R3 low-speed size", int'(resp_len), 8);
        hs(1'b1); chk("R5 still data", int'(stage), 2);
        token(1); hs(1'b1);
        token(1); chk("R4 low-speed remainder", int'(resp_len), 4);
        hs(1'b1); chk("R5 done low-speed", int'(stage), 5);

        // host-to-device, status IN with and without ack
        mtag = "R6"; full_speed = 1'b1; mps_code = 2'd1;
        setup(0, 40, 8);
        out_pkt(16); chk("R6 ack 1", int'(resp_code), ACK); chk("R6 stay data", int'(stage), 3);
        out_pkt(16); chk("R6 ack 2", int'(resp_code), ACK);
        out_pkt(8);  chk("R6 final ack", int'(resp_code), ACK); chk("R6 status in", int'(stage), 7);
        mtag = "R9";
        token(1); chk("R9 zero-length data", int'(resp_code), DATA); chk("R9 len 0", int'(resp_len), 0);
        hs(1'b0); chk("R9 no done without ack", int'(xfer_done), 0);
        token(1); hs(1'b1); chk("R9 done on ack", int'(xfer_done), 1);

        // oversize and overshoot
        mtag = "R7";
        setup(0, 40, 8);
        out_pkt(17); chk("R7 oversize stalls", int'(resp_code), STALL); chk("R7 halted", int'(halted), 1);
        setup(0, 40, 8);
        out_pkt(16); out_pkt(16);
        out_pkt(10); chk("R7 overshoot stalls", int'(resp_code), STALL);

        // rejected setup lengths
        mtag = "R2";
        setup(1, 99, 7);
        chk("R2 7 bytes no answer", int'(resp_valid), 0);
        chk("R2 req_len kept", int'(req_len), 40);
        chk("R2 back to idle", int'(stage), 0);
        setup(1, 99, 9);
        chk("R2 9 bytes no answer", int'(resp_valid), 0);
        chk("R2 req_dir kept", int'(req_dir), 0);
        token(1); chk("R2 idle ignores IN", int'(resp_valid), 0);

        // zero-length requests
        mtag = "R9";
        setup(0, 0, 8); chk("R9 straight to status", int'(stage), 7);
        token(1); hs(1'b1); chk("R9 done", int'(xfer_done), 1);
        setup(1, 0, 8); chk("R9 dir1 len0 status in", int'(stage), 7);
        token(1); hs(1'b1);

        // non-empty status OUT
        mtag = "R10";
        setup(1, 8, 8);
        token(1); hs(1'b1); chk("R5 short and exact", int'(stage), 5);
        out_pkt(3); chk("R10 non-empty status stalls", int'(resp_code), STALL);

        // abort mid-transfer
        mtag = "R11"; mps_code = 2'd3;
        setup(1, 200, 8);
        token(1); hs(1'b1);
        setup(0, 4, 8);
        chk("R11 abort new len", int'(req_len), 4);
        chk("R11 abort new dir", int'(req_dir), 0);
        out_pkt(4); chk("R6 after abort", int'(stage), 7);
        token(1); hs(1'b1); chk("R9 final done", int'(xfer_done), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule